// File: doc/BRIEF.md
# Banked Register Access SPI Sequencer

This block sits on the host side of a byte-level SPI link to a peripheral. The peripheral's control registers are spread over four banks. The host issues one register request at a time: read, write, set bits or clear bits. Each request names a 7-bit register (bank and address), may carry a data byte, and may be flagged as a slow-class register. The sequencer turns each request into one or more chip-select framed byte transactions and reports the result with a single-cycle done pulse.

The sequencer keeps its own copy of the bank currently selected in the peripheral. When a request targets a banked address in a different bank, the sequencer first issues its own bank-change transactions. It first clears the two bank-select bits of the control register at address 0x1F. If the new bank is not zero, it then sets them to the new bank. Addresses 0x1B to 0x1F are visible in every bank and never cause a bank change. A read of a slow-class register adds a zero byte to the transaction and takes the data from that second transfer.

Back-pressure works as follows. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle. Byte offers on the transmit side follow valid/ready: `spi_tx_byte` stays stable while `spi_tx_valid` waits for `spi_tx_ready`. The receive side has no ready signal. The sequencer waits for `spi_rx_valid` after every accepted byte before it moves on.

Top module: `bank_spi_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `req_ready` is 1, and `spi_tx_valid` and `done` are 0. The bank copy is 0, so a first request to any bank-0 address issues no bank change.
- R2: A command byte carries the opcode in bits 7:5 and the 5-bit address in bits 4:0. The opcodes are read 000, write 010, set-bits 100 and clear-bits 101. `req_op` encodes read=0, write=1, set=2, clear=3.
- R3: A read of a normal register is a one-byte transaction. `done_data` is the byte returned during that command transfer.
- R4: A write, set or clear is a two-byte transaction: the command byte, then `req_data`.
- R5: When a banked address (below 0x1B) is in a bank that differs from the bank copy, two transactions precede the access. The first is 0xBF then 0x03 (clear-bits on 0x1F). The second is 0x9F then the bank number (set-bits on 0x1F). The bank copy then holds the new bank.
- R6: A change to bank 0 issues only the clear-bits transaction before the access.
- R7: No bank-change transaction is issued when the requested bank equals the bank copy.
- R8: Addresses 0x1B to 0x1F never cause a bank change and leave the bank copy unchanged.
- R9: A read with `req_slow` set is one transaction of two bytes, the command and then 0x00. `done_data` is the byte returned during the second transfer.
- R10: `req_ready` drops in the cycle after a request is taken. `done` is a one-cycle pulse raised only after chip select has been released for the access.
- R11: While `spi_tx_valid` is high and `spi_tx_ready` is low, `spi_tx_valid` stays high and `spi_tx_byte` does not change.
- R12: Each transaction has its own chip-select assertion. Chip select is released between a bank-change transaction and the transaction that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_reg | input | 7 | Bank in bits 6:5, address in bits 4:0 |
| req_op | input | 2 | 0 read, 1 write, 2 set bits, 3 clear bits |
| req_slow | input | 1 | Slow-class register (dummy byte on read) |
| req_data | input | 8 | Write data or bit mask |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | 8 | Read result, valid with `done` |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_tx_valid | output | 1 | Byte offered to the serializer |
| spi_tx_ready | input | 1 | Serializer takes the byte |
| spi_tx_byte | output | 8 | Byte to shift out |
| spi_rx_valid | input | 1 | Returned byte available (one cycle) |
| spi_rx_byte | input | 8 | Byte shifted in during the transfer |

## Verification
The test requests walk the bank copy through all four banks. Each of the following cases is tried: a request to the same bank, a change to a non-zero bank, a change to bank 0, and shared addresses reached from a foreign bank. Those cases separate a missing bank change, a redundant one, a stray set-bits transaction and a shared access wrongly treated as banked. Reads are tried both with and without the slow flag, and each returned byte is made unique to the transfer it answers. That shows which transfer the result was taken from. A run with a stalling serializer shows the transmit byte holding under back-pressure, and a second reset shows the bank copy returning to 0.

// File: rtl/bspi_pkg.sv
package bspi_pkg;
  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_SET = 2'd2,
    OP_CLR = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    TX_BCLR = 2'd0,
    TX_BSET = 2'd1,
    TX_ACC  = 2'd2
  } txn_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEND = 3'd1,
    ST_WAIT = 3'd2,
    ST_GAP  = 3'd3
  } st_e;

  localparam logic [2:0] OPC_RD  = 3'b000;
  localparam logic [2:0] OPC_WR  = 3'b010;
  localparam logic [2:0] OPC_SET = 3'b100;
  localparam logic [2:0] OPC_CLR = 3'b101;
endpackage

// File: rtl/bspi_bank_cache.sv
module bspi_bank_cache #(
  parameter int AW          = 5,
  parameter int BW          = 2,
  parameter int SHARED_BASE = 27
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] load_val,
  input  logic [AW-1:0] q_addr,
  input  logic [BW-1:0] q_bank,
  output logic          need_switch
);
  localparam logic [AW-1:0] SHARED_LO = AW'(SHARED_BASE);

  logic [BW-1:0] cur_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_bank <= '0;
    else if (load) cur_bank <= load_val;
  end

  assign need_switch = (q_addr < SHARED_LO) && (q_bank != cur_bank);
endmodule

// File: rtl/bspi_cmd_gen.sv
module bspi_cmd_gen
  import bspi_pkg::*;
#(
  parameter int AW       = 5,
  parameter int BW       = 2,
  parameter int DW       = 8,
  parameter int SEL_ADDR = 31
) (
  input  txn_e          kind,
  input  op_e           op,
  input  logic          slow,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] bank,
  input  logic [DW-1:0] data,
  input  logic          idx,
  output logic [DW-1:0] tx_byte,
  output logic          last
);
  localparam int OPW = DW - AW;
  localparam logic [AW-1:0] SEL = AW'(SEL_ADDR);
  localparam logic [DW-1:0] BSEL_MASK = DW'((1 << BW) - 1);

  logic [OPW-1:0] opc;

  always_comb begin
    unique case (op)
      OP_RD:   opc = OPW'(OPC_RD);
      OP_WR:   opc = OPW'(OPC_WR);
      OP_SET:  opc = OPW'(OPC_SET);
      default: opc = OPW'(OPC_CLR);
    endcase
  end

  always_comb begin
    tx_byte = '0;
    last    = idx;
    unique case (kind)
      TX_BCLR: tx_byte = idx ? BSEL_MASK : {OPW'(OPC_CLR), SEL};
      TX_BSET: tx_byte = idx ? DW'(bank) : {OPW'(OPC_SET), SEL};
      default: begin
        if (!idx)            tx_byte = {opc, addr};
        else if (op == OP_RD) tx_byte = '0;
        else                 tx_byte = data;
        if (op == OP_RD && !slow) last = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/bank_spi_seq.sv
module bank_spi_seq
  import bspi_pkg::*;
#(
  parameter int AW          = 5,
  parameter int BW          = 2,
  parameter int DW          = 8,
  parameter int SHARED_BASE = 27,
  parameter int SEL_ADDR    = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW+BW-1:0] req_reg,
  input  logic [1:0]       req_op,
  input  logic             req_slow,
  input  logic [DW-1:0]    req_data,
  output logic             done,
  output logic [DW-1:0]    done_data,
  output logic             spi_cs_n,
  output logic             spi_tx_valid,
  input  logic             spi_tx_ready,
  output logic [DW-1:0]    spi_tx_byte,
  input  logic             spi_rx_valid,
  input  logic [DW-1:0]    spi_rx_byte
);
  st_e           st;
  txn_e          kind;
  logic          idx;
  op_e           r_op;
  logic          r_slow;
  logic [AW-1:0] r_addr;
  logic [BW-1:0] r_bank;
  logic [DW-1:0] r_data;

  logic          need_switch;
  logic          byte_last;
  logic          take;
  logic          xfer_end;
  logic          cache_load;
  logic [BW-1:0] cache_val;

  assign take       = req_valid && req_ready;
  assign xfer_end   = (st == ST_WAIT) && spi_rx_valid;
  assign cache_load = xfer_end && byte_last && (kind != TX_ACC);
  assign cache_val  = (kind == TX_BSET) ? r_bank : '0;

  bspi_bank_cache #(.AW(AW), .BW(BW), .SHARED_BASE(SHARED_BASE)) u_cache (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cache_load),
    .load_val   (cache_val),
    .q_addr     (req_reg[AW-1:0]),
    .q_bank     (req_reg[AW+BW-1:AW]),
    .need_switch(need_switch)
  );

  bspi_cmd_gen #(.AW(AW), .BW(BW), .DW(DW), .SEL_ADDR(SEL_ADDR)) u_gen (
    .kind   (kind),
    .op     (r_op),
    .slow   (r_slow),
    .addr   (r_addr),
    .bank   (r_bank),
    .data   (r_data),
    .idx    (idx),
    .tx_byte(spi_tx_byte),
    .last   (byte_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      kind      <= TX_ACC;
      idx       <= 1'b0;
      r_op      <= OP_RD;
      r_slow    <= 1'b0;
      r_addr    <= '0;
      r_bank    <= '0;
      r_data    <= '0;
      done      <= 1'b0;
      done_data <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (take) begin
          r_op   <= op_e'(req_op);
          r_slow <= req_slow;
          r_addr <= req_reg[AW-1:0];
          r_bank <= req_reg[AW+BW-1:AW];
          r_data <= req_data;
          kind   <= need_switch ? TX_BCLR : TX_ACC;
          idx    <= 1'b0;
          st     <= ST_SEND;
        end
        ST_SEND: if (spi_tx_ready) st <= ST_WAIT;
        ST_WAIT: if (spi_rx_valid) begin
          if (!byte_last) begin
            idx <= 1'b1;
            st  <= ST_SEND;
          end else begin
            idx <= 1'b0;
            unique case (kind)
              TX_BCLR: begin
                kind <= (r_bank != '0) ? TX_BSET : TX_ACC;
                st   <= ST_GAP;
              end
              TX_BSET: begin
                kind <= TX_ACC;
                st   <= ST_GAP;
              end
              default: begin
                done      <= 1'b1;
                done_data <= (r_op == OP_RD) ? spi_rx_byte : '0;
                st        <= ST_IDLE;
              end
            endcase
          end
        end
        default: st <= ST_SEND;
      endcase
    end
  end

  assign req_ready    = (st == ST_IDLE);
  assign spi_tx_valid = (st == ST_SEND);
  assign spi_cs_n     = !((st == ST_SEND) || (st == ST_WAIT));
endmodule

// File: rtl/bspi_seq_chk.sv
module bspi_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic          spi_cs_n,
  input logic          spi_tx_valid,
  input logic          spi_tx_ready,
  input logic [DW-1:0] spi_tx_byte
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (spi_cs_n && req_ready && !spi_tx_valid && !done));

  assert_ready_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n);

  assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_tx_valid && !spi_tx_ready) |=> (spi_tx_valid && $stable(spi_tx_byte)));

  assert_select_starts_byte_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> spi_tx_valid);
endmodule

bind bank_spi_seq bspi_seq_chk #(.DW(DW)) u_bspi_seq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .done        (done),
  .spi_cs_n    (spi_cs_n),
  .spi_tx_valid(spi_tx_valid),
  .spi_tx_ready(spi_tx_ready),
  .spi_tx_byte (spi_tx_byte)
);

// File: tb/test_bank_spi_seq.sv
module test_bank_spi_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [6:0] req_reg = '0;
  logic [1:0] req_op = '0;
  logic       req_slow = 1'b0;
  logic [7:0] req_data = '0;
  logic       done;
  logic [7:0] done_data;
  logic       spi_cs_n;
  logic       spi_tx_valid;
  logic       spi_tx_ready = 1'b1;
  logic [7:0] spi_tx_byte;
  logic       spi_rx_valid = 1'b0;
  logic [7:0] spi_rx_byte = '0;

  always #4 clk = ~clk;

  bank_spi_seq i_bank_spi_seq (.*);

  int checks = 0;
  int fails = 0;

  // serializer model state
  logic [7:0] log_b [256];
  int         log_s [256];
  int         log_n = 0;
  int         sess = 0;
  logic       prev_cs = 1'b1;
  int         resp_cnt = 0;
  int         resp_idx = 0;
  int         wait_cnt = 0;
  logic [7:0] held = '0;
  int         hold_err = 0;
  bit         stall_en = 0;

  // expected model
  logic [1:0] mcache = 2'd0;
  logic [7:0] exp_b [8];
  int         exp_s [8];
  int         exp_n;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      spi_rx_valid = 1'b0;
      resp_cnt = 0;
      wait_cnt = 0;
      spi_tx_ready = 1'b1;
      prev_cs = 1'b1;
    end else begin
      spi_rx_valid = 1'b0;
      if (resp_cnt > 0) begin
        resp_cnt--;
        if (resp_cnt == 0) begin
          spi_rx_valid = 1'b1;
          spi_rx_byte = 8'h40 + 8'(resp_idx);
        end
      end
      if (!spi_cs_n && prev_cs) sess++;
      prev_cs = spi_cs_n;
      if (!spi_tx_valid) begin
        spi_tx_ready = !stall_en;
        wait_cnt = 0;
      end else if (!spi_tx_ready) begin
        if (wait_cnt == 0) held = spi_tx_byte;
        else if (spi_tx_byte != held) hold_err++;
        wait_cnt++;
        if (wait_cnt >= 3) spi_tx_ready = 1'b1;
      end
      if (spi_tx_valid && spi_tx_ready) begin
        log_b[log_n] = spi_tx_byte;
        log_s[log_n] = sess;
        resp_idx = log_n;
        log_n++;
        resp_cnt = 2;
      end
    end
  end

  function automatic void push(int s, logic [7:0] b);
    exp_b[exp_n] = b;
    exp_s[exp_n] = s;
    exp_n++;
  endfunction

  task automatic run_req(logic [6:0] rg, logic [1:0] op, bit slow, logic [7:0] d);
    logic [4:0] a;
    logic [1:0] bk;
    logic [2:0] opc;
    int s;
    int start;
    int s0;
    int t;
    logic [7:0] got;
    string tag;
    a = rg[4:0];
    bk = rg[6:5];
    exp_n = 0;
    s = 0;
    tag = (op == 2'd0) ? (slow ? "R9" : "R3") : "R4";
    if (a >= 5'h1B && bk != mcache) tag = "R8";
    else if (bk == mcache) begin
      if (op != 2'd0 || slow) tag = (op == 2'd0) ? "R9" : "R7";
    end
    if (a < 5'h1B && bk != mcache) begin
      tag = (bk == 2'd0) ? "R6" : "R5";
      push(s, 8'hBF); push(s, 8'h03); s++;
      if (bk != 2'd0) begin
        push(s, 8'h9F); push(s, {6'd0, bk}); s++;
      end
      mcache = bk;
    end
    case (op)
      2'd0: opc = 3'b000;
      2'd1: opc = 3'b010;
      2'd2: opc = 3'b100;
      default: opc = 3'b101;
    endcase
    push(s, {opc, a});
    if (op == 2'd0 && slow) push(s, 8'h00);
    if (op != 2'd0) push(s, d);

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    start = log_n;
    s0 = sess;
    req_valid = 1'b1; req_reg = rg; req_op = op; req_slow = slow; req_data = d;
    @(negedge clk);
    chk(!req_ready, "R10", "ready after take", int'(req_ready), 0);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    chk(done, "R10", "done seen", int'(done), 1);
    got = done_data;
    @(negedge clk);
    chk(!done, "R10", "done width", int'(done), 0);
    chk(log_n - start == exp_n, tag, "byte count", log_n - start, exp_n);
    for (int i = 0; i < exp_n && i < log_n - start; i++) begin
      chk(log_b[start+i] == exp_b[i], tag, "byte value", int'(log_b[start+i]), int'(exp_b[i]));
      chk(log_s[start+i] - s0 == exp_s[i] + 1, (i > 0 && exp_s[i] != exp_s[i-1]) ? "R12" : tag,
          "transaction number", log_s[start+i] - s0, exp_s[i] + 1);
    end
    if (log_n > start + exp_n - 1)
      chk(log_b[start+exp_n-1 - (op == 2'd0 && slow ? 1 : (op == 2'd0 ? 0 : 1))] == {opc, a},
          "R2", "command byte", int'(log_b[start+exp_n-1-(op == 2'd0 && slow ? 1 : (op == 2'd0 ? 0 : 1))]),
          int'({opc, a}));
    if (op == 2'd0)
      chk(got == 8'h40 + 8'(start + exp_n - 1), slow ? "R9" : "R3", "read data",
          int'(got), int'(8'h40 + 8'(start + exp_n - 1)));
  endtask

  // {reg[6:0], op[1:0], slow, data[7:0]}
  localparam logic [17:0] VEC [10] = '{
    {2'd0, 5'h05, 2'd0, 1'b0, 8'h00},
    {2'd2, 5'h04, 2'd1, 1'b0, 8'h5A},
    {2'd2, 5'h10, 2'd2, 1'b0, 8'h81},
    {2'd1, 5'h1C, 2'd3, 1'b0, 8'h0F},
    {2'd2, 5'h12, 2'd0, 1'b1, 8'h00},
    {2'd0, 5'h08, 2'd1, 1'b0, 8'h33},
    {2'd3, 5'h1A, 2'd0, 1'b0, 8'h00},
    {2'd3, 5'h1F, 2'd2, 1'b0, 8'h04},
    {2'd1, 5'h00, 2'd0, 1'b1, 8'h00},
    {2'd1, 5'h02, 2'd3, 1'b0, 8'hFF}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n && req_ready && !spi_tx_valid && !done, "R1", "reset outputs",
        {spi_cs_n, req_ready, spi_tx_valid, done}, 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n && req_ready, "R1", "idle after reset", {spi_cs_n, req_ready}, 2'b11);

    for (int v = 0; v < 10; v++)
      run_req(VEC[v][17:11], VEC[v][10:9], VEC[v][8], VEC[v][7:0]);

    // R11: stalling serializer, with a bank change to exercise several bytes
    stall_en = 1;
    hold_err = 0;
    run_req({2'd3, 5'h06}, 2'd1, 1'b0, 8'hC3);
    stall_en = 0;
    chk(hold_err == 0, "R11", "tx byte held under stall", hold_err, 0);

    // R1: second reset returns the bank copy to 0
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(spi_cs_n && req_ready && !done, "R1", "outputs in second reset",
        {spi_cs_n, req_ready, done}, 3'b110);
    rst_n = 1'b1;
    mcache = 2'd0;
    run_req({2'd0, 5'h03}, 2'd0, 1'b0, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule